// File: doc/BRIEF.md
# Printer Port Forward Transmitter

This block sends bytes from a host to a printer-style peripheral over an 8-bit parallel bus. The host pushes bytes into a small queue through a simple write port. A handshake sequencer takes one byte at a time from the head of the queue and places it on the data bus. It waits a setup interval, then pulls the active-low strobe down. It keeps the strobe low until a minimum pulse has elapsed and the peripheral has answered by raising busy. It then waits for busy to drop and observes a hold gap before it presents the next byte.

All intervals are counted in ticks, and one tick is a fixed number of core clocks. Each phase restarts its own tick prescaler, so every interval is an exact multiple of the core clock. The busy input is taken as synchronous to the core clock.

The block also drives three active-low control lines from a small control word. A new control word never takes effect while the strobe is low. A direction status output always reports the forward direction.

Top module: `lpt_fwd_engine`

## Requirements
- R1: The queue holds DEPTH (default 16) bytes. Bytes reach the bus in the order they were written. `fifo_full` is high exactly when DEPTH bytes are held, and `fifo_empty` is high exactly when none are held.
- R2: A write while `fifo_full` is high is dropped. The queued contents and the order in which they are sent do not change.
- R3: A byte is placed on `pd_o` exactly SETUP_TICKS·TICK_DIV clocks before `strobe_n` falls, and the bus does not change during that time.
- R4: `strobe_n` stays low for at least PULSE_TICKS·TICK_DIV clocks. If busy has not yet been seen high, the strobe stays low until the first clock edge that sees `busy_i` high. The low width is therefore max(PULSE_TICKS·TICK_DIV, clocks from the strobe fall to the first busy-high edge).
- R5: `pd_o` never changes on a clock edge at which `busy_i` is high. While `busy_i` is high, no byte is taken from the queue, even when the block is idle.
- R6: After a strobe, the next byte is not placed on the bus until `busy_i` has been low for at least HOLD_TICKS·TICK_DIV clocks.
- R7: When the queue is empty and the block is idle, `strobe_n` stays high and `pd_o` does not change.
- R8: `dir_o` is always 0, which encodes the forward direction.
- R9: `ctl_wr` loads `ctl_data`. Bit 0 asserts init, bit 1 asserts autofeed and bit 2 asserts select-in, and each output drives the inverse of its bit. Outside a strobe pulse, the outputs change one clock after the write. A word written while `strobe_n` is low takes effect one clock after `strobe_n` returns high.
- R10: Synchronous `rst` (active high) empties the queue and returns the sequencer to idle. After reset, `strobe_n`=1, `pd_o`=0 and all three control outputs are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Push `wr_data` into the queue |
| wr_data | input | 8 | Byte to queue |
| ctl_wr | input | 1 | Load the control word |
| ctl_data | input | 3 | Control word: bit0 init, bit1 autofeed, bit2 select-in |
| busy_i | input | 1 | Peripheral busy, active high |
| pd_o | output | 8 | Parallel data bus |
| strobe_n | output | 1 | Data strobe, active low |
| init_n | output | 1 | Initialize line, active low |
| autofd_n | output | 1 | Autofeed line, active low |
| selin_n | output | 1 | Select-in line, active low |
| dir_o | output | 1 | Transfer direction, 0 = forward |
| fifo_full | output | 1 | Queue full |
| fifo_empty | output | 1 | Queue empty |

## Verification
The case that is hardest to reach from the ports is a full queue that still receives writes. The sequencer drains the queue as fast as bytes arrive unless something stops it. The bench therefore raises busy before any byte is written, which keeps the idle sequencer from taking a byte. It then pushes one byte more than the queue holds, and releases busy only after checking the flags and the quiet bus. A sweep over peripheral response delays on both sides of the minimum pulse width covers the stretched-strobe path, including busy dropping while the strobe is still low.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_SETUP,
    SQ_PULSE,
    SQ_RELEASE,
    SQ_HOLD
  } seq_state_t;

  // bit2 select-in, bit1 autofeed, bit0 init (asserted = 1)
  typedef struct packed {
    logic sel_in;
    logic auto_fd;
    logic init;
  } ctl_bits_t;

  localparam logic DIR_FORWARD = 1'b0;

  function automatic int phase_cycles(input int ticks, input int div);
    return ticks * div;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic logic [15:0] sat_inc16(input logic [15:0] v);
    return (v == 16'hFFFF) ? v : v + 16'd1;
  endfunction

endpackage

// File: rtl/lpt_fifo.sv
module lpt_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] head,
  output logic             full_o,
  output logic             empty_o
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    count_q;
  logic             push_ok, pop_ok;

  assign full_o  = (count_q == CW'(DEPTH));
  assign empty_o = (count_q == '0);
  assign push_ok = wr_en && !full_o;
  assign pop_ok  = rd_en && !empty_o;
  assign head    = mem[rd_ptr_q];

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr_q] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= ptr_next(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= ptr_next(rd_ptr_q);
      case ({push_ok, pop_ok})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (full_o && wr_en && !rd_en) |=> (full_o && $stable(count_q)));

  // R1
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count_q <= CW'(DEPTH));

endmodule

// File: rtl/lpt_phase_timer.sv
module lpt_phase_timer #(
  parameter int TICK_DIV  = 4,
  parameter int MAX_TICKS = 24,
  localparam int TW = $clog2(MAX_TICKS + 1),
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_ticks,
  output logic          done
);

  logic [TW-1:0] tk_q;
  logic          tick_w;

  generate
    if (TICK_DIV == 1) begin : g_nodiv
      assign tick_w = 1'b1;
    end else begin : g_div
      logic [PW-1:0] presc_q;
      always_ff @(posedge clk) begin
        if (rst || load)
          presc_q <= '0;
        else if (tk_q != '0)
          presc_q <= (presc_q == PW'(TICK_DIV - 1)) ? '0 : presc_q + 1'b1;
      end
      assign tick_w = (presc_q == PW'(TICK_DIV - 1));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                      tk_q <= '0;
    else if (load)                tk_q <= load_ticks;
    else if (tk_q != '0 && tick_w) tk_q <= tk_q - 1'b1;
  end

  // the phase ends on the clock that consumes its last tick
  assign done = (tk_q == '0) || (tk_q == TW'(1) && tick_w);

endmodule

// File: rtl/lpt_hs_seq.sv
module lpt_hs_seq
  import lpt_pkg::*;
#(
  parameter int TICK_DIV    = 4,
  parameter int SETUP_TICKS = 24,
  parameter int PULSE_TICKS = 24,
  parameter int HOLD_TICKS  = 12,
  localparam int MAXT = max3(SETUP_TICKS, PULSE_TICKS, HOLD_TICKS),
  localparam int TW   = $clog2(MAXT + 1),
  localparam int SETUP_CYC = phase_cycles(SETUP_TICKS, TICK_DIV),
  localparam int PULSE_CYC = phase_cycles(PULSE_TICKS, TICK_DIV),
  localparam int HOLD_CYC  = phase_cycles(HOLD_TICKS, TICK_DIV)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       busy_i,
  input  logic       fifo_empty,
  input  logic [7:0] fifo_head,
  output logic       fifo_pop,
  output logic [7:0] pd_o,
  output logic       strobe_n,
  output logic       in_pulse,
  output logic       seq_idle
);

  seq_state_t    state_q, state_d;
  logic [7:0]    data_q;
  logic          busy_seen_q;
  logic          tmr_load, tmr_done;
  logic [TW-1:0] tmr_ticks;

  // named events for the checks below
  logic ev_present, ev_strobe_fall, ev_strobe_rise, ev_busy_release;

  lpt_phase_timer #(.TICK_DIV(TICK_DIV), .MAX_TICKS(MAXT)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .load_ticks(tmr_ticks), .done(tmr_done)
  );

  always_comb begin
    state_d   = state_q;
    fifo_pop  = 1'b0;
    tmr_load  = 1'b0;
    tmr_ticks = '0;
    unique case (state_q)
      SQ_IDLE: if (!fifo_empty && !busy_i) begin
        fifo_pop  = 1'b1;
        tmr_load  = 1'b1;
        tmr_ticks = TW'(SETUP_TICKS);
        state_d   = SQ_SETUP;
      end
      SQ_SETUP: if (tmr_done) begin
        tmr_load  = 1'b1;
        tmr_ticks = TW'(PULSE_TICKS);
        state_d   = SQ_PULSE;
      end
      SQ_PULSE: if (tmr_done && (busy_seen_q || busy_i)) state_d = SQ_RELEASE;
      SQ_RELEASE: if (!busy_i) begin
        tmr_load  = 1'b1;
        tmr_ticks = TW'(HOLD_TICKS);
        state_d   = SQ_HOLD;
      end
      SQ_HOLD: if (tmr_done) state_d = SQ_IDLE;
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= SQ_IDLE;
      data_q      <= '0;
      busy_seen_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (fifo_pop) data_q <= fifo_head;
      if (state_q != SQ_PULSE) busy_seen_q <= 1'b0;
      else if (busy_i)         busy_seen_q <= 1'b1;
    end
  end

  assign pd_o     = data_q;
  assign strobe_n = (state_q != SQ_PULSE);
  assign in_pulse = (state_q == SQ_PULSE);
  assign seq_idle = (state_q == SQ_IDLE);

  assign ev_present      = fifo_pop;
  assign ev_strobe_fall  = (state_q == SQ_SETUP) && tmr_done;
  assign ev_strobe_rise  = (state_q == SQ_PULSE) && (state_d == SQ_RELEASE);
  assign ev_busy_release = (state_q == SQ_RELEASE) && !busy_i;

  // independent age counters used only by the checks
  logic [15:0] setup_age_q, low_age_q, quiet_age_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      setup_age_q <= '0;
      low_age_q   <= '0;
      quiet_age_q <= 16'hFFFF;
    end else begin
      setup_age_q <= ev_present ? '0 : sat_inc16(setup_age_q);
      low_age_q   <= (state_q == SQ_PULSE) ? sat_inc16(low_age_q) : '0;
      quiet_age_q <= (busy_i && state_q != SQ_IDLE) ? '0 : sat_inc16(quiet_age_q);
    end
  end

  // R3
  setup_window_chk: assert property (@(posedge clk) disable iff (rst)
    ev_strobe_fall |-> (setup_age_q >= 16'(SETUP_CYC - 1)));

  // R4
  pulse_min_chk: assert property (@(posedge clk) disable iff (rst)
    ev_strobe_rise |-> (low_age_q >= 16'(PULSE_CYC - 1)));

  // R5
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy_i |=> $stable(pd_o));

  // R6
  hold_gap_chk: assert property (@(posedge clk) disable iff (rst)
    ev_present |-> (quiet_age_q >= 16'(HOLD_CYC)));

  // R6
  release_order_chk: assert property (@(posedge clk) disable iff (rst)
    ev_busy_release |=> strobe_n);

endmodule

// File: rtl/lpt_fwd_engine.sv
module lpt_fwd_engine
  import lpt_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int TICK_DIV    = 4,
  parameter int SETUP_TICKS = 24,
  parameter int PULSE_TICKS = 24,
  parameter int HOLD_TICKS  = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       ctl_wr,
  input  logic [2:0] ctl_data,
  input  logic       busy_i,
  output logic [7:0] pd_o,
  output logic       strobe_n,
  output logic       init_n,
  output logic       autofd_n,
  output logic       selin_n,
  output logic       dir_o,
  output logic       fifo_full,
  output logic       fifo_empty
);

  logic       q_pop, q_full, q_empty, in_pulse, seq_idle;
  logic [7:0] q_head;
  ctl_bits_t  ctl_pend_q, ctl_q;

  lpt_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(q_pop), .head(q_head), .full_o(q_full), .empty_o(q_empty)
  );

  lpt_hs_seq #(
    .TICK_DIV(TICK_DIV), .SETUP_TICKS(SETUP_TICKS),
    .PULSE_TICKS(PULSE_TICKS), .HOLD_TICKS(HOLD_TICKS)
  ) u_seq (
    .clk(clk), .rst(rst), .busy_i(busy_i), .fifo_empty(q_empty),
    .fifo_head(q_head), .fifo_pop(q_pop), .pd_o(pd_o), .strobe_n(strobe_n),
    .in_pulse(in_pulse), .seq_idle(seq_idle)
  );

  // control word: staged, applied only outside the strobe pulse
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_pend_q <= '0;
      ctl_q      <= '0;
    end else begin
      if (ctl_wr) ctl_pend_q <= ctl_bits_t'(ctl_data);
      if (!in_pulse) ctl_q <= ctl_wr ? ctl_bits_t'(ctl_data) : ctl_pend_q;
    end
  end

  assign init_n     = ~ctl_q.init;
  assign autofd_n   = ~ctl_q.auto_fd;
  assign selin_n    = ~ctl_q.sel_in;
  assign dir_o      = DIR_FORWARD;
  assign fifo_full  = q_full;
  assign fifo_empty = q_empty;

  // R9
  ctl_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe_n |=> $stable({init_n, autofd_n, selin_n}));

  // R7
  idle_rest_chk: assert property (@(posedge clk) disable iff (rst)
    (seq_idle && fifo_empty) |=> (strobe_n && $stable(pd_o)));

endmodule

// File: tb/sim_lpt_fwd_engine.sv
`timescale 1ns/1ps
module sim_lpt_fwd_engine;

  localparam int DIV = 4;
  localparam int S = 24 * DIV;
  localparam int P = 24 * DIV;
  localparam int H = 12 * DIV;

  logic clk = 1'b0;
  logic rst, wr_en, ctl_wr, busy_i;
  logic [7:0] wr_data;
  logic [2:0] ctl_data;
  logic [7:0] pd_o;
  logic strobe_n, init_n, autofd_n, selin_n, dir_o, fifo_full, fifo_empty;

  always #2 clk = ~clk;

  lpt_fwd_engine u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .ctl_wr(ctl_wr), .ctl_data(ctl_data), .busy_i(busy_i),
    .pd_o(pd_o), .strobe_n(strobe_n), .init_n(init_n), .autofd_n(autofd_n),
    .selin_n(selin_n), .dir_o(dir_o), .fifo_full(fifo_full), .fifo_empty(fifo_empty)
  );

  int total = 0;
  int bad   = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor state
  bit         mon_on = 1'b0;
  logic [7:0] prev_pd;
  logic       prev_str;
  int age = 0, low_cnt = 0, gap_cnt = 0, busy_viol = 0, cur_r = 1;
  bit gap_armed = 1'b0;
  logic [7:0] rx_q[$];
  logic [7:0] exp_q[$];

  always begin
    @(posedge clk); #1;
    if (mon_on) begin
      if (gap_armed) gap_cnt++;
      if (pd_o !== prev_pd) begin
        if (busy_i) busy_viol++;
        if (gap_armed) begin
          chk(gap_cnt >= H + 2, "R6 hold gap", gap_cnt, H + 2);
          gap_armed = 1'b0;
        end
        age = 0;
      end else begin
        age++;
      end
      if (!strobe_n && prev_str) begin
        rx_q.push_back(pd_o);
        chk(age == S, "R3 setup", age, S);
        low_cnt = 1;
      end else if (!strobe_n) begin
        low_cnt++;
      end
      if (strobe_n && !prev_str) begin
        int ew;
        ew = (P > cur_r + 1) ? P : cur_r + 1;
        chk(low_cnt == ew, "R4 strobe width", low_cnt, ew);
      end
      prev_pd  = pd_o;
      prev_str = strobe_n;
    end
  end

  task automatic mon_start();
    prev_pd  = pd_o;
    prev_str = strobe_n;
    age = 0; low_cnt = 0; gap_armed = 1'b0; busy_viol = 0;
    mon_on = 1'b1;
  endtask

  task automatic wr_byte(input logic [7:0] b);
    wr_en = 1'b1; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic write_ctl(input logic [2:0] c);
    ctl_wr = 1'b1; ctl_data = c;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic serve(input int r, input int b);
    while (strobe_n !== 1'b1) @(negedge clk);
    cur_r = r;
    do @(negedge clk); while (strobe_n !== 1'b0);
    repeat (r) @(negedge clk);
    busy_i = 1'b1;
    repeat (b) @(negedge clk);
    busy_i = 1'b0;
    gap_cnt = 0;
    gap_armed = 1'b1;
  endtask

  task automatic cmp_rx(input string req);
    chk(rx_q.size() == exp_q.size(), req, rx_q.size(), exp_q.size());
    foreach (exp_q[i]) begin
      if (i < rx_q.size()) chk(rx_q[i] == exp_q[i], req, rx_q[i], exp_q[i]);
    end
  endtask

  task automatic idle_watch(input int n);
    logic [7:0] hp;
    int v;
    hp = pd_o; v = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (strobe_n !== 1'b1 || pd_o !== hp) v++;
    end
    chk(v == 0, "R7 idle rest", v, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not complete");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int rs[6] = '{1, 20, 95, 96, 97, 150};
    int bs[2] = '{1, 30};
    int viol;
    logic [7:0] hold_pd;

    rst = 1'b1; wr_en = 1'b0; wr_data = '0; ctl_wr = 1'b0; ctl_data = '0; busy_i = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(strobe_n === 1'b1, "R10 strobe after reset", strobe_n, 1);
    chk(fifo_empty === 1'b1 && fifo_full === 1'b0, "R10 queue after reset", {fifo_full, fifo_empty}, 1);
    chk(pd_o === 8'h00, "R10 bus after reset", pd_o, 0);
    chk({selin_n, autofd_n, init_n} === 3'b111, "R10 controls after reset", {selin_n, autofd_n, init_n}, 7);
    chk(dir_o === 1'b0, "R8 direction", dir_o, 0);
    mon_start();

    // sweep of peripheral response delays (R1, R3, R4, R6)
    for (int k = 0; k < 12; k++) begin
      logic [7:0] b;
      b = 8'((k * 37 + 41) & 255);
      exp_q.push_back(b);
      wr_byte(b);
    end
    for (int bi = 0; bi < 2; bi++)
      for (int ri = 0; ri < 6; ri++) serve(rs[ri], bs[bi]);
    repeat (H + 20) @(negedge clk);
    cmp_rx("R1 order");
    chk(fifo_empty === 1'b1, "R1 empty after drain", fifo_empty, 1);
    idle_watch(300);
    chk(busy_viol == 0, "R5 bus moved while busy", busy_viol, 0);

    // control word, outside and during a pulse (R9)
    write_ctl(3'b101);
    chk({selin_n, autofd_n, init_n} === 3'b010, "R9 control idle", {selin_n, autofd_n, init_n}, 2);
    rx_q.delete(); exp_q.delete();
    fork
      serve(120, 5);
      begin
        wr_byte(8'h5A);
        while (strobe_n !== 1'b0) @(negedge clk);
        write_ctl(3'b010);
        viol = 0;
        while (strobe_n !== 1'b1) begin
          if ({selin_n, autofd_n, init_n} !== 3'b010) viol++;
          @(negedge clk);
        end
        chk(viol == 0, "R9 control changed mid-strobe", viol, 0);
        chk({selin_n, autofd_n, init_n} === 3'b010, "R9 control at strobe rise", {selin_n, autofd_n, init_n}, 2);
        @(negedge clk);
        chk({selin_n, autofd_n, init_n} === 3'b101, "R9 control applied", {selin_n, autofd_n, init_n}, 5);
      end
    join
    repeat (H + 20) @(negedge clk);

    // overfill while busy holds the idle engine (R1, R2, R5)
    gap_armed = 1'b0; rx_q.delete(); exp_q.delete(); busy_viol = 0;
    busy_i = 1'b1;
    @(negedge clk);
    hold_pd = pd_o;
    for (int k = 0; k < 17; k++) begin
      if (k < 16) exp_q.push_back(8'(8'hA0 + k));
      wr_byte(8'(8'hA0 + k));
    end
    repeat (5) @(negedge clk);
    chk(fifo_full === 1'b1, "R2 full flag", fifo_full, 1);
    chk(fifo_empty === 1'b0, "R1 not empty", fifo_empty, 0);
    chk(strobe_n === 1'b1, "R5 no strobe while busy", strobe_n, 1);
    chk(pd_o === hold_pd, "R5 bus held while busy", pd_o, hold_pd);
    busy_i = 1'b0;
    for (int k = 0; k < 16; k++) serve(3, 2);
    repeat (H + 20) @(negedge clk);
    cmp_rx("R2 overflow dropped");
    chk(fifo_empty === 1'b1, "R1 empty after overfill drain", fifo_empty, 1);
    chk(busy_viol == 0, "R5 bus moved while busy", busy_viol, 0);

    // reset in the middle of a strobe (R10, R7)
    mon_on = 1'b0;
    wr_byte(8'h33); wr_byte(8'h44); wr_byte(8'h55);
    while (strobe_n !== 1'b0) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(strobe_n === 1'b1, "R10 strobe released", strobe_n, 1);
    chk(fifo_empty === 1'b1 && fifo_full === 1'b0, "R10 queue cleared", {fifo_full, fifo_empty}, 1);
    chk(pd_o === 8'h00, "R10 bus cleared", pd_o, 0);
    chk({selin_n, autofd_n, init_n} === 3'b111, "R10 controls cleared", {selin_n, autofd_n, init_n}, 7);
    idle_watch(300);
    chk(dir_o === 1'b0, "R8 direction", dir_o, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule